// File: doc/BRIEF.md
# Circular Buffer Address Pointer Modifier

The block computes the next value of a 24-bit data-memory address pointer after an access. Each request carries the current pointer, a signed step, a bank select naming which of two data memories the pointer serves, a stack flag, and the two loop-configuration fields. Each data memory has its own loop field.

A loop field either leaves the pointer linear or turns the neighbourhood of the pointer into a circular buffer. There are three buffer styles, each with its own length formula and alignment block. When the stepped offset runs past either end of the buffer, it folds back inside the buffer, so software can run delay lines and coefficient rings with no extra instructions. Stack-pointer updates bypass all looping.

Requests enter over a valid/ready handshake and results leave over a second valid/ready handshake, with one register stage in between. A result held under back-pressure stalls the input side. The input is taken only when `in_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The configuration fields and the bank select are sampled together with the request.

Top module: `circ_ptr_step`

## Requirements
- R1: With loop mode 0 (field bits [6:5] = 00), the result is `in_ptr` plus the sign-extended `in_step`, modulo 2^24.
- R2: Loop mode 1 with size value N (bits [4:0]) from 2 to 8 defines a buffer of 2^N words that starts at the 2^N-aligned address at or below the pointer.
- R3: Loop mode 2 with size value P from 0 to 14 defines a buffer of 64*(P+1) words that starts on the 1024-word boundary at or below the pointer.
- R4: Loop mode 3 with size value Q from 0 to 30 defines a buffer of 2*(Q+1) words that starts on the 64-word boundary at or below the pointer.
- R5: The wrap rule applies when a buffer is active, the pointer offset from the buffer start is below the length, and |step| is less than the length. The result is the buffer start plus ((offset + step) mod length), for both positive and negative steps.
- R6: When a buffer is active but the pointer offset from its aligned start is already at or beyond the length, the result is the linear sum of R1.
- R7: `in_bank` = 0 uses loop field `in_loop_lo` (pointers 0 to 3); `in_bank` = 1 uses `in_loop_hi` (pointers 4 to 7). The other field has no effect on the result.
- R8: With `in_stack` high, the result is `in_ptr` + 1 modulo 2^24, whatever the step and loop fields are.
- R9: A size value outside the range of its mode (mode 1: N < 2 or N > 8; mode 2: P > 14; mode 3: Q = 31) makes that field behave as linear (R1).
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high. A request accepted at a clock edge appears on `out_ptr` with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, `out_ptr` stays unchanged.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_ptr | input | 24 | Current pointer value |
| in_step | input | 11 | Signed post-modify step |
| in_bank | input | 1 | Memory select: 0 = pointers 0-3, 1 = pointers 4-7 |
| in_stack | input | 1 | Stack update: plain +1, no looping |
| in_loop_lo | input | 7 | Loop field for bank 0: [6:5] mode, [4:0] size |
| in_loop_hi | input | 7 | Loop field for bank 1: [6:5] mode, [4:0] size |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ptr | output | 24 | Next pointer value |

## Verification
The bench uses the default parameters: a 24-bit pointer and an 11-bit step. An 11-bit step is just wide enough to reach the largest buffer length minus one in both directions. With these widths, the bench can sweep every mode against all 32 size codes, including every out-of-range code. Each combination is tried at offsets at the buffer start, the middle, the last word, the first word past the end and the last word of the alignment block, and with steps of 0, ±1, 2 or 3, and ±(length−1). Every case also places a contrasting configuration in the unused bank, and a separate pass drives stack updates, carry across the top of the address space, and a stalled output.

// File: rtl/ptrmod_pkg.sv
package ptrmod_pkg;

  localparam int MODE_W  = 2;
  localparam int SIZE_W  = 5;
  localparam int LEN_W   = 11;  // holds lengths up to 1024 words
  localparam int ALIGN_W = 4;   // alignment exponents up to 10

  typedef enum logic [MODE_W-1:0] {
    LOOP_LINEAR = 2'd0,
    LOOP_POW2   = 2'd1,
    LOOP_MUL64  = 2'd2,
    LOOP_MUL2   = 2'd3
  } loop_mode_e;

  typedef struct packed {
    loop_mode_e        mode;
    logic [SIZE_W-1:0] size;
  } loop_cfg_t;

  typedef struct packed {
    logic               active;
    logic [LEN_W-1:0]   len;
    logic [ALIGN_W-1:0] align;
  } loop_geom_t;

endpackage

// File: rtl/ptrmod_loop_decode.sv
module ptrmod_loop_decode
  import ptrmod_pkg::*;
(
  input  loop_cfg_t  cfg,
  output loop_geom_t geom
);

  always_comb begin
    geom = '0;
    case (cfg.mode)
      LOOP_POW2: begin
        if (cfg.size >= 5'd2 && cfg.size <= 5'd8) begin
          geom.active = 1'b1;
          geom.len    = LEN_W'(1) << cfg.size;
          geom.align  = ALIGN_W'(cfg.size);
        end
      end
      LOOP_MUL64: begin
        if (cfg.size <= 5'd14) begin
          geom.active = 1'b1;
          geom.len    = (LEN_W'(cfg.size) + LEN_W'(1)) << 6;
          geom.align  = ALIGN_W'(10);
        end
      end
      LOOP_MUL2: begin
        if (cfg.size <= 5'd30) begin
          geom.active = 1'b1;
          geom.len    = (LEN_W'(cfg.size) + LEN_W'(1)) << 1;
          geom.align  = ALIGN_W'(6);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ptrmod_wrap.sv
module ptrmod_wrap
  import ptrmod_pkg::*;
#(
  parameter int PTR_W  = 24,
  parameter int STEP_W = 11
) (
  input  logic [PTR_W-1:0]         ptr,
  input  logic signed [STEP_W-1:0] step,
  input  loop_geom_t               geom,
  input  logic                     stack,
  output logic [PTR_W-1:0]         base,
  output logic                     in_range,
  output logic [PTR_W-1:0]         next
);

  localparam int SUM_W = ((STEP_W > LEN_W) ? STEP_W : LEN_W) + 2;

  logic [PTR_W-1:0]        low_mask;
  logic [PTR_W-1:0]        step_ext;
  logic [PTR_W-1:0]        linear_nxt;
  logic [LEN_W-1:0]        off;
  logic signed [SUM_W-1:0] len_s;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] wrapped;

  always_comb begin
    low_mask   = ~({PTR_W{1'b1}} << geom.align);
    base       = ptr & ~low_mask;
    off        = LEN_W'(ptr & low_mask);
    in_range   = off < geom.len;
    step_ext   = {{(PTR_W-STEP_W){step[STEP_W-1]}}, step};
    linear_nxt = ptr + step_ext;

    len_s = $signed(SUM_W'(geom.len));
    sum   = $signed(SUM_W'(off)) + $signed({{(SUM_W-STEP_W){step[STEP_W-1]}}, step});
    if (sum < 0)
      wrapped = sum + len_s;
    else if (sum >= len_s)
      wrapped = sum - len_s;
    else
      wrapped = sum;

    if (stack)
      next = ptr + PTR_W'(1);
    else if (geom.active && in_range)
      next = base | PTR_W'($unsigned(LEN_W'(wrapped)));
    else
      next = linear_nxt;
  end

endmodule

// File: rtl/circ_ptr_step.sv
module circ_ptr_step
  import ptrmod_pkg::*;
#(
  parameter int PTR_W  = 24,
  parameter int STEP_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PTR_W-1:0]         in_ptr,
  input  logic signed [STEP_W-1:0] in_step,
  input  logic                     in_bank,
  input  logic                     in_stack,
  input  logic [6:0]               in_loop_lo,
  input  logic [6:0]               in_loop_hi,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [PTR_W-1:0]         out_ptr
);

  localparam int NUM_BANKS = 2;

  loop_cfg_t  bank_cfg  [NUM_BANKS];
  loop_geom_t bank_geom [NUM_BANKS];
  loop_geom_t geom_sel;
  logic [PTR_W-1:0] base_w;
  logic [PTR_W-1:0] next_w;
  logic             in_range_w;
  logic             accept;

  assign bank_cfg[0] = loop_cfg_t'(in_loop_lo);
  assign bank_cfg[1] = loop_cfg_t'(in_loop_hi);

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      ptrmod_loop_decode u_dec (
        .cfg  (bank_cfg[g]),
        .geom (bank_geom[g])
      );
    end
  endgenerate

  assign geom_sel = bank_geom[in_bank];

  ptrmod_wrap #(.PTR_W(PTR_W), .STEP_W(STEP_W)) u_wrap (
    .ptr      (in_ptr),
    .step     (in_step),
    .geom     (geom_sel),
    .stack    (in_stack),
    .base     (base_w),
    .in_range (in_range_w),
    .next     (next_w)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ptr   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_ptr   <= next_w;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ptr)));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_stack) |=> (out_ptr == $past(in_ptr) + PTR_W'(1)));

  assert_inbuf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_stack && geom_sel.active && in_range_w)
      |=> ((out_ptr - $past(base_w)) < PTR_W'($past(geom_sel.len))));

  assert_linear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_stack && !geom_sel.active)
      |=> (out_ptr == $past(in_ptr) + PTR_W'($past(in_step))));

  assert_nowrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_stack && geom_sel.active && !in_range_w)
      |=> (out_ptr == $past(in_ptr) + PTR_W'($past(in_step))));

endmodule

// File: tb/circ_ptr_step_test.sv
`timescale 1ns/1ps
module circ_ptr_step_test;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [23:0]        in_ptr = '0;
  logic signed [10:0] in_step = '0;
  logic               in_bank = 1'b0;
  logic               in_stack = 1'b0;
  logic [6:0]         in_loop_lo = '0;
  logic [6:0]         in_loop_hi = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [23:0]        out_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [6:0] OTHER_CFG = {2'd3, 5'd0};  // two-word ring

  always #2.5 clk = ~clk;

  circ_ptr_step uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ptr(in_ptr), .in_step(in_step), .in_bank(in_bank), .in_stack(in_stack),
    .in_loop_lo(in_loop_lo), .in_loop_hi(in_loop_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_ptr(out_ptr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void geometry(input int mode, input int sz,
                                   output bit act, output int len, output int blk);
    act = 1'b0; len = 16; blk = 16;
    if (mode == 1 && sz >= 2 && sz <= 8) begin act = 1'b1; len = 1 << sz; blk = len; end
    if (mode == 2 && sz <= 14) begin act = 1'b1; len = 64 * (sz + 1); blk = 1024; end
    if (mode == 3 && sz <= 30) begin act = 1'b1; len = 2 * (sz + 1); blk = 64; end
  endfunction

  function automatic logic [23:0] model(input int ptr, input int st, input logic [6:0] cfg,
                                        input bit stk);
    bit act; int len, blk, off, base, r;
    if (stk) return 24'(ptr + 1);
    geometry(int'(cfg[6:5]), int'(cfg[4:0]), act, len, blk);
    if (!act) return 24'(ptr + st);
    off = ptr % blk;
    base = ptr - off;
    if (off >= len) return 24'(ptr + st);
    r = ((off + st) % len + len) % len;
    return 24'(base + r);
  endfunction

  task automatic xfer(input logic [23:0] p, input int st, input logic [6:0] cfg,
                      input bit bank, input bit stk, input string tag);
    logic [23:0] exp;
    exp = model(int'(p), st, cfg, stk);
    @(negedge clk);
    in_ptr = p; in_step = st[10:0]; in_bank = bank; in_stack = stk;
    in_loop_lo = bank ? OTHER_CFG : cfg;
    in_loop_hi = bank ? cfg : OTHER_CFG;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check(tag, 32'(out_ptr), 32'(exp));
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 out_valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 out_valid idle", 32'(out_valid), 32'd0);
    check("R11 in_ready idle", 32'(in_ready), 32'd1);

    // Sweep of every mode and size code
    for (int mode = 0; mode < 4; mode++) begin
      for (int sz = 0; sz < 32; sz++) begin
        bit act; int len, blk;
        geometry(mode, sz, act, len, blk);
        for (int oi = 0; oi < 7; oi++) begin
          int off;
          int region;
          case (oi)
            0: off = 0;
            1: off = 1;
            2: off = len / 2;
            3: off = len - 2;
            4: off = len - 1;
            5: off = len;
            default: off = blk - 1;
          endcase
          if (off >= blk) off = blk - 1;
          region = 32'h5A3000 + ((mode * 32 + sz) % 8) * 4096;
          for (int si = 0; si < 6; si++) begin
            int st;
            string tag;
            case (si)
              0: st = 1;
              1: st = -1;
              2: st = len - 1;
              3: st = -(len - 1);
              4: st = 0;
              default: st = (len > 3) ? 3 : ((len > 2) ? 2 : 1);
            endcase
            if (act) tag = (mode == 1) ? "R2" : ((mode == 2) ? "R3" : "R4");
            else     tag = (mode == 0) ? "R1" : "R9";
            if (act && off >= len) tag = {tag, "/R6"};
            else if (act)          tag = {tag, "/R5"};
            tag = {tag, $sformatf("/R7 mode %0d size %0d off %0d step %0d", mode, sz, off, st)};
            xfer(24'(region + off), st, {2'(mode), 5'(sz)}, ((oi + si) % 2) == 1, 1'b0, tag);
          end
        end
      end
    end

    // Linear carry across the top of the address space
    xfer(24'hFFFFFE, 5, 7'd0, 1'b0, 1'b0, "R1 top wrap");
    xfer(24'h000002, -4, 7'd0, 1'b1, 1'b0, "R1 bottom wrap");

    // Stack updates ignore loop field and step
    xfer(24'h001003, -5, {2'd1, 5'd2}, 1'b0, 1'b1, "R8 stack in pow2 ring");
    xfer(24'h00043F, 7, {2'd3, 5'd31}, 1'b1, 1'b1, "R8 stack in mul2 field");
    xfer(24'hFFFFFF, 0, {2'd2, 5'd0}, 1'b0, 1'b1, "R8 stack top");

    // Back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_ptr = 24'd100; in_step = 11'sd1; in_bank = 1'b0; in_stack = 1'b0;
    in_loop_lo = 7'd0; in_loop_hi = 7'd0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 first result", 32'(out_ptr), 32'd101);
    in_ptr = 24'd200; in_step = 11'sd2;
    check("R10 in_ready low while stalled", 32'(in_ready), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R10 held valid", 32'(out_valid), 32'd1);
      check("R10 held value", 32'(out_ptr), 32'd101);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result after release", 32'(out_ptr), 32'd202);
    @(posedge clk);
    @(negedge clk);
    check("R10 drained", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule